// File: doc/BRIEF.md
# Multi-lane TDM Output Serializer

This block turns parallel audio words into bit-serial time-division-multiplexed streams on several data lanes. It runs on the bit clock. Each frame is started by a rising edge of the (optionally inverted) frame sync. A programmable delay measured in bit clocks follows, and then a programmable number of equally wide slots are sent back to back on every lane, most significant bit first. Outputs are registered on the rising edge, so a receiver samples them on the falling edge.

Each lane has its own slot-enable bitmap. In an enabled slot the lane asks its sample source for a word through a valid/ready handshake. In a disabled slot it sends the shared mute word instead and makes no request. If a requested word is not available, the lane sends the mute word and latches a sticky underrun flag.

Two active-low soft resets gate the block, one for the output side and one for the input side, together with an enable. Serialization only begins after a strict bring-up order. While the block is idle, every lane sits at zero.

Top module: `tdmo_serializer`

## Requirements
- R1: After `rst_n` is released, and at any time the block is not running, every `lane_o` bit is 0 and every `smp_ready_o` bit is 0. Clearing `cfg_enable` makes all lanes 0 from the next clock edge on.
- R2: The block runs only once the following order has been seen on consecutive settings: both `cfg_out_rst_n` and `cfg_in_rst_n` low, then `cfg_out_rst_n` high while `cfg_in_rst_n` is still low, then both high, with `cfg_enable` high. If the input reset is released first, the block stays idle until both resets are asserted again.
- R3: Let edge 0 be the first clock edge at which the effective frame sync is sampled high after having been low. The first bit of slot 0 appears on the lanes after edge `cfg_skew`, where `cfg_skew` runs from 0 to 31.
- R4: A frame holds `cfg_slots_m1`+1 slots of `cfg_slot_width_m1`+1 bits each, sent with no gaps. After the last bit of the last slot, the lanes are 0 until the next frame.
- R5: A slot sends the low `cfg_slot_width_m1`+1 bits of its word, starting at bit `cfg_slot_width_m1` and ending at bit 0.
- R6: Slot s of lane l carries a sample only when `cfg_lane_mask[l*32+s]` is 1. Otherwise that slot carries the mute word `cfg_mute_value` and no request is made.
- R7: `smp_ready_o[l]` is high exactly in the cycle that ends at the edge where an enabled slot of lane l begins. The word on `smp_data_i` (lane l at bits l*32 and up) is taken at that edge if `smp_valid_i[l]` is high.
- R8: When an enabled slot begins with `smp_valid_i[l]` low, the lane sends `cfg_mute_value` for that slot and `underrun_o[l]` becomes 1. The flag stays 1 until both soft resets are low together, or until `rst_n` is asserted.
- R9: With `cfg_fs_invert` high, the frame sync is taken as the inverse of `fsync_i`, so a falling edge of `fsync_i` starts a frame.
- R10: Clearing `cfg_enable` in the middle of a frame stops the frame: the lanes are 0 from the next edge on and no further requests are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| cfg_enable | input | 1 | Serializer enable |
| cfg_out_rst_n | input | 1 | Output-side soft reset, active low |
| cfg_in_rst_n | input | 1 | Input-side soft reset, active low |
| cfg_fs_invert | input | 1 | Invert the frame sync polarity |
| cfg_slot_width_m1 | input | 5 | Slot width in bits, minus one |
| cfg_slots_m1 | input | 5 | Slots per frame, minus one |
| cfg_skew | input | 5 | Bit clocks from the frame sync edge to the first data bit |
| cfg_lane_mask | input | 128 | Per-lane slot-enable bitmaps, 32 bits per lane |
| cfg_mute_value | input | 32 | Word sent in empty or disabled slots |
| fsync_i | input | 1 | Frame sync |
| smp_valid_i | input | 4 | Per-lane sample valid |
| smp_data_i | input | 128 | Per-lane sample words, 32 bits per lane |
| smp_ready_o | output | 4 | Per-lane sample request |
| lane_o | output | 4 | Serial data lanes |
| underrun_o | output | 4 | Sticky per-lane underrun flags |

## Verification
The bench builds the block with its default parameters: four lanes, 32-bit words and 32-bit slot bitmaps. This brings within reach the widest slot (32 bits), the longest frame (32 slots), the largest skew (31), and slots addressed at both ends of every lane's bitmap. Random frames mix skew, slot width, slot count, polarity, masks and missing samples. Directed frames cover 1-bit slots, 32-bit slots, zero skew, an enable dropped mid-frame, and a bring-up done in the wrong order.

// File: rtl/tdmo_pkg.sv
package tdmo_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARMED,
        SEQ_OUT_UP,
        SEQ_READY
    } seq_e;

    typedef enum logic [1:0] {
        PH_WAIT,
        PH_SKEW,
        PH_ACTIVE
    } phase_e;
endpackage

// File: rtl/tdmo_reset_seq.sv
module tdmo_reset_seq
    import tdmo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic out_rst_n,
    input  logic in_rst_n,
    input  logic enable,
    output logic run_o,
    output logic flag_clr_o
);
    typedef struct packed {
        seq_e st;
    } seq_st_t;

    seq_st_t q, d;
    logic both_low;

    always_comb begin
        d        = q;
        both_low = !out_rst_n && !in_rst_n;
        if (both_low) begin
            d.st = SEQ_ARMED;
        end else begin
            case (q.st)
                SEQ_ARMED:  d.st = (out_rst_n && !in_rst_n) ? SEQ_OUT_UP : SEQ_IDLE;
                SEQ_OUT_UP: begin
                    if (out_rst_n && in_rst_n) d.st = SEQ_READY;
                    else if (!out_rst_n)       d.st = SEQ_IDLE;
                end
                SEQ_READY:  if (!(out_rst_n && in_rst_n)) d.st = SEQ_IDLE;
                default:    d.st = q.st;
            endcase
        end
        run_o      = (q.st == SEQ_READY) && enable;
        flag_clr_o = both_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SEQ_IDLE};
        else        q <= d;
    end
endmodule

// File: rtl/tdmo_frame_ctl.sv
module tdmo_frame_ctl
    import tdmo_pkg::*;
#(
    parameter int BIT_W  = 5,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fs,
    input  logic [BIT_W-1:0]  skew,
    input  logic [BIT_W-1:0]  width_m1,
    input  logic [SLOT_W-1:0] slots_m1,
    output logic              slot_start_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic              adv_o,
    output logic [BIT_W-1:0]  adv_idx_o
);
    typedef struct packed {
        phase_e            phase;
        logic              fs;
        logic [BIT_W-1:0]  skew;
        logic [BIT_W-1:0]  bits_left;
        logic [SLOT_W-1:0] slot;
    } frm_st_t;

    frm_st_t q, d;
    logic fs_rise;
    logic begin0;

    always_comb begin
        d            = q;
        d.fs         = fs;
        fs_rise      = fs && !q.fs;
        begin0       = 1'b0;
        slot_start_o = 1'b0;
        slot_idx_o   = '0;
        adv_o        = 1'b0;
        adv_idx_o    = '0;
        if (!run) begin
            d.phase = PH_WAIT;
        end else if (fs_rise) begin
            if (skew == '0) begin
                begin0 = 1'b1;
            end else begin
                d.phase = PH_SKEW;
                d.skew  = skew;
            end
        end else begin
            case (q.phase)
                PH_SKEW: begin
                    if (q.skew == BIT_W'(1)) begin0 = 1'b1;
                    else                     d.skew = q.skew - BIT_W'(1);
                end
                PH_ACTIVE: begin
                    if (q.bits_left == '0) begin
                        if (q.slot == slots_m1) begin
                            d.phase = PH_WAIT;
                        end else begin
                            slot_start_o = 1'b1;
                            slot_idx_o   = q.slot + SLOT_W'(1);
                            d.slot       = q.slot + SLOT_W'(1);
                            d.bits_left  = width_m1;
                        end
                    end else begin
                        adv_o       = 1'b1;
                        adv_idx_o   = q.bits_left - BIT_W'(1);
                        d.bits_left = q.bits_left - BIT_W'(1);
                    end
                end
                default: d.phase = PH_WAIT;
            endcase
        end
        if (begin0) begin
            slot_start_o = 1'b1;
            slot_idx_o   = '0;
            d.slot       = '0;
            d.bits_left  = width_m1;
            d.phase      = PH_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_WAIT, fs: 1'b0, skew: '0, bits_left: '0, slot: '0};
        else        q <= d;
    end
endmodule

// File: rtl/tdmo_lane.sv
module tdmo_lane #(
    parameter int WORD_W    = 32,
    parameter int MAX_SLOTS = 32,
    parameter int BIT_W     = 5,
    parameter int SLOT_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flag_clr,
    input  logic                 slot_start,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic                 adv,
    input  logic [BIT_W-1:0]     adv_idx,
    input  logic [BIT_W-1:0]     width_m1,
    input  logic [MAX_SLOTS-1:0] mask,
    input  logic [WORD_W-1:0]    mute,
    input  logic                 valid,
    input  logic [WORD_W-1:0]    data,
    output logic                 ready_o,
    output logic                 bit_o,
    output logic                 underrun_o
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              bit_out;
        logic              flag;
    } lane_st_t;

    lane_st_t q, d;
    logic slot_on;
    logic [WORD_W-1:0] sel;

    always_comb begin
        d       = q;
        slot_on = mask[slot_idx];
        sel     = (slot_on && valid) ? data : mute;
        ready_o = slot_start && slot_on;
        if (slot_start) begin
            d.word    = sel;
            d.bit_out = sel[width_m1];
        end else if (adv) begin
            d.bit_out = q.word[adv_idx];
        end else begin
            d.bit_out = 1'b0;
        end
        if (flag_clr)                            d.flag = 1'b0;
        else if (slot_start && slot_on && !valid) d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{word: '0, bit_out: 1'b0, flag: 1'b0};
        else        q <= d;
    end

    assign bit_o      = q.bit_out;
    assign underrun_o = q.flag;
endmodule

// File: rtl/tdmo_serializer.sv
module tdmo_serializer #(
    parameter int LANES     = 4,
    parameter int WORD_W    = 32,
    parameter int MAX_SLOTS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_enable,
    input  logic                       cfg_out_rst_n,
    input  logic                       cfg_in_rst_n,
    input  logic                       cfg_fs_invert,
    input  logic [$clog2(WORD_W)-1:0]    cfg_slot_width_m1,
    input  logic [$clog2(MAX_SLOTS)-1:0] cfg_slots_m1,
    input  logic [$clog2(WORD_W)-1:0]    cfg_skew,
    input  logic [LANES*MAX_SLOTS-1:0] cfg_lane_mask,
    input  logic [WORD_W-1:0]          cfg_mute_value,
    input  logic                       fsync_i,
    input  logic [LANES-1:0]           smp_valid_i,
    input  logic [LANES*WORD_W-1:0]    smp_data_i,
    output logic [LANES-1:0]           smp_ready_o,
    output logic [LANES-1:0]           lane_o,
    output logic [LANES-1:0]           underrun_o
);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int SLOT_W = $clog2(MAX_SLOTS);

    logic              run;
    logic              flag_clr;
    logic              slot_start;
    logic [SLOT_W-1:0] slot_idx;
    logic              adv;
    logic [BIT_W-1:0]  adv_idx;

    tdmo_reset_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_rst_n  (cfg_out_rst_n),
        .in_rst_n   (cfg_in_rst_n),
        .enable     (cfg_enable),
        .run_o      (run),
        .flag_clr_o (flag_clr)
    );

    tdmo_frame_ctl #(.BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .fs           (fsync_i ^ cfg_fs_invert),
        .skew         (cfg_skew),
        .width_m1     (cfg_slot_width_m1),
        .slots_m1     (cfg_slots_m1),
        .slot_start_o (slot_start),
        .slot_idx_o   (slot_idx),
        .adv_o        (adv),
        .adv_idx_o    (adv_idx)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tdmo_lane #(
            .WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS), .BIT_W(BIT_W), .SLOT_W(SLOT_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .flag_clr   (flag_clr),
            .slot_start (slot_start),
            .slot_idx   (slot_idx),
            .adv        (adv),
            .adv_idx    (adv_idx),
            .width_m1   (cfg_slot_width_m1),
            .mask       (cfg_lane_mask[l*MAX_SLOTS +: MAX_SLOTS]),
            .mute       (cfg_mute_value),
            .valid      (smp_valid_i[l]),
            .data       (smp_data_i[l*WORD_W +: WORD_W]),
            .ready_o    (smp_ready_o[l]),
            .bit_o      (lane_o[l]),
            .underrun_o (underrun_o[l])
        );
    end
endmodule

// File: rtl/tdmo_serializer_chk.sv
module tdmo_serializer_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             cfg_out_rst_n,
    input logic             cfg_in_rst_n,
    input logic [LANES-1:0] smp_valid_i,
    input logic [LANES-1:0] smp_ready_o,
    input logic [LANES-1:0] lane_o,
    input logic [LANES-1:0] underrun_o
);
    assert_idle_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (lane_o == '0));

    assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (smp_ready_o == '0));

    assert_seq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|smp_ready_o) |-> $past(cfg_out_rst_n && cfg_in_rst_n));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out_rst_n || cfg_in_rst_n) |=> ((underrun_o & $past(underrun_o)) == $past(underrun_o)));

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_ready_o[l] && !smp_valid_i[l] && (cfg_out_rst_n || cfg_in_rst_n)) |=> underrun_o[l]);
    end
endmodule

bind tdmo_serializer tdmo_serializer_chk #(.LANES(LANES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_enable    (cfg_enable),
    .cfg_out_rst_n (cfg_out_rst_n),
    .cfg_in_rst_n  (cfg_in_rst_n),
    .smp_valid_i   (smp_valid_i),
    .smp_ready_o   (smp_ready_o),
    .lane_o        (lane_o),
    .underrun_o    (underrun_o)
);

// File: tb/tdmo_serializer_tb_top.sv
module tdmo_serializer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int WORD_W     = 32;
    localparam int MAX_SLOTS  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0, cfg_out_rst_n = 1'b0, cfg_in_rst_n = 1'b0, cfg_fs_invert = 1'b0;
    logic [4:0] cfg_slot_width_m1 = '0, cfg_slots_m1 = '0, cfg_skew = '0;
    logic [LANES*MAX_SLOTS-1:0] cfg_lane_mask = '0;
    logic [WORD_W-1:0] cfg_mute_value = '0;
    logic fsync_i = 1'b0;
    logic [LANES-1:0] smp_valid_i = '0;
    logic [LANES*WORD_W-1:0] smp_data_i = '0;
    logic [LANES-1:0] smp_ready_o, lane_o, underrun_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int f_init, f_wm1, f_sm1, f_stop;
    bit f_act;
    logic [WORD_W-1:0] f_samp [LANES][MAX_SLOTS];
    bit f_vld [LANES][MAX_SLOTS];
    logic [LANES-1:0] exp_under = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdmo_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_out_rst_n(cfg_out_rst_n),
        .cfg_in_rst_n(cfg_in_rst_n), .cfg_fs_invert(cfg_fs_invert),
        .cfg_slot_width_m1(cfg_slot_width_m1), .cfg_slots_m1(cfg_slots_m1), .cfg_skew(cfg_skew),
        .cfg_lane_mask(cfg_lane_mask), .cfg_mute_value(cfg_mute_value), .fsync_i(fsync_i),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .smp_ready_o(smp_ready_o),
        .lane_o(lane_o), .underrun_o(underrun_o)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit stopped(int e);
        return (f_stop >= 0) && (e >= f_stop);
    endfunction

    function automatic int rel_of(int e);
        return e - f_init;
    endfunction

    function automatic bit in_frame(int e);
        int rel = rel_of(e);
        return rel >= 0 && rel < (f_wm1 + 1) * (f_sm1 + 1);
    endfunction

    function automatic logic exp_lane(int l, int e);
        int w = f_wm1 + 1;
        int rel = rel_of(e);
        logic [WORD_W-1:0] word;
        if (!f_act || !in_frame(e) || stopped(e)) return 1'b0;
        word = (cfg_lane_mask[l*MAX_SLOTS + rel/w] && f_vld[l][rel/w]) ? f_samp[l][rel/w] : cfg_mute_value;
        return word[f_wm1 - rel % w];
    endfunction

    function automatic string tag_of(int l, int e);
        int w = f_wm1 + 1;
        if (!f_act) return "R2";
        if (stopped(e)) return "R10";
        if (rel_of(e) < 0) return "R3";
        if (!in_frame(e)) return "R4";
        if (!cfg_lane_mask[l*MAX_SLOTS + rel_of(e)/w]) return "R6";
        return cfg_fs_invert ? "R9" : "R5";
    endfunction

    task automatic run_frame(int init, int wm1, int sm1, bit inv, bit act, int stop_at);
        int total;
        @(negedge clk);
        f_init = init; f_wm1 = wm1; f_sm1 = sm1; f_act = act; f_stop = stop_at;
        cfg_skew = 5'(init); cfg_slot_width_m1 = 5'(wm1); cfg_slots_m1 = 5'(sm1);
        cfg_fs_invert = inv; fsync_i = inv;
        cfg_mute_value = $urandom;
        for (int l = 0; l < LANES; l++) begin
            cfg_lane_mask[l*MAX_SLOTS +: MAX_SLOTS] = $urandom;
            for (int s = 0; s < MAX_SLOTS; s++) begin
                f_samp[l][s] = $urandom;
                f_vld[l][s]  = ($urandom % 5) != 0;
            end
        end
        total = init + (wm1 + 1) * (sm1 + 1);
        for (int t = 0; t <= total + 1; t++) begin
            bit start;
            int rel;
            @(negedge clk);
            if (t >= 1)
                for (int l = 0; l < LANES; l++)
                    chk(tag_of(l, t - 1), 64'(lane_o[l]), 64'(exp_lane(l, t - 1)));
            if (t == stop_at) cfg_enable = 1'b0;
            fsync_i = (t == 0) ? ~inv : inv;
            rel = t - init;
            start = rel >= 0 && (rel % (wm1 + 1)) == 0 && rel / (wm1 + 1) <= sm1;
            for (int l = 0; l < LANES; l++) begin
                if (start) begin
                    smp_valid_i[l] = f_vld[l][rel / (wm1 + 1)];
                    smp_data_i[l*WORD_W +: WORD_W] = f_samp[l][rel / (wm1 + 1)];
                end else begin
                    smp_valid_i[l] = $urandom;
                    smp_data_i[l*WORD_W +: WORD_W] = $urandom;
                end
            end
            #1;
            for (int l = 0; l < LANES; l++) begin
                bit er;
                er = act && start && !stopped(t) && cfg_lane_mask[l*MAX_SLOTS + rel / (wm1 + 1)];
                chk(act ? (er ? "R7" : "R6") : "R2", 64'(smp_ready_o[l]), 64'(er));
                if (er && !smp_valid_i[l]) exp_under[l] = 1'b1;
            end
        end
        chk("R8", 64'(underrun_o), 64'(exp_under));
    endtask

    task automatic bring_up(bit good_order);
        @(negedge clk); cfg_out_rst_n = 1'b0; cfg_in_rst_n = 1'b0; cfg_enable = 1'b0;
        @(negedge clk);
        if (good_order) cfg_out_rst_n = 1'b1; else cfg_in_rst_n = 1'b1;
        exp_under = '0;
        chk("R8", 64'(underrun_o), 64'(0));
        @(negedge clk); cfg_out_rst_n = 1'b1; cfg_in_rst_n = 1'b1;
        @(negedge clk); cfg_enable = 1'b1;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk("R1", 64'(lane_o), 64'(0));
        chk("R1", 64'(smp_ready_o), 64'(0));
        chk("R1", 64'(underrun_o), 64'(0));
        rst_n = 1'b1;
        // not yet brought up: frame must be ignored (R2)
        run_frame(2, 7, 1, 1'b0, 1'b0, -1);
        bring_up(1'b1);
        run_frame(0, 31, 1, 1'b0, 1'b1, -1);   // widest slots, zero skew
        run_frame(31, 0, 31, 1'b0, 1'b1, -1);  // 1-bit slots, max skew, full bitmap
        run_frame(1, 15, 7, 1'b1, 1'b1, -1);   // inverted sync (R9)
        for (int i = 0; i < 24; i++)
            run_frame($urandom % 32, $urandom % 32, $urandom % 8, 1'(($urandom)), 1'b1, -1);
        // enable dropped mid-frame (R10)
        run_frame(3, 9, 3, 1'b0, 1'b1, 3 + 14);
        repeat (2) @(negedge clk);
        chk("R1", 64'(lane_o), 64'(0));
        cfg_enable = 1'b1;
        run_frame(0, 3, 5, 1'b0, 1'b1, -1);
        // wrong release order keeps the block idle (R2)
        bring_up(1'b0);
        run_frame(1, 4, 2, 1'b0, 1'b0, -1);
        bring_up(1'b1);
        run_frame(2, 5, 3, 1'b1, 1'b1, -1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule